// File: doc/BRIEF.md
# Shared-Access Budget Enforcer

This block sits beside one processor core and watches the core's requests to a shared memory path. Time is divided into a repeating frame, measured by a timebase enable, and the frame holds a small number of process windows. Each window has a start slot, an end slot and an access allowance. Inside a window the block counts every shared access that it lets through. When the count reaches the allowance minus a configured safety margin, the block stops granting shared access for the rest of that window and signals an interrupt.

The block never stalls or alters an access that it lets through. It only drives a grant-enable that the core's bus interface ANDs with its own request. Software sets up the window table, the frame length, the margin and the total capacity once at start-up through a small write-only configuration port. It then sets the run bit. The block also checks that the allowances of all valid windows fit inside the total capacity and flags any table that does not.

Top module: `shared_budget_enforcer`

## Requirements
- R1: Configuration writes use address bit 4 to choose between a window (0) and a global register (1). For a window, bits 3:2 give the window index and bits 1:0 give the field: 0 start slot, 1 end slot, 2 allowance. For a global register, bits 1:0 give 0 frame length, 1 margin, 2 capacity, 3 command. In the command register, data bit 0 is the run bit and data bit 1 clears the sticky flag. While run is 1, the frame slot counter advances on each cycle with `tick` high and wraps to 0 after slot frame length − 1. While run is 0 the counter is held at 0. Window i is active when start_i < end_i and start_i ≤ slot < end_i. The lowest index wins on overlap. `stat_active` and `stat_window` report the decoded window one cycle later, and `stat_window` is 0 when no window is active.
- R2: `grant_en` is registered. It is high in a cycle only if a window was decoded active in the previous cycle and that window is not suspended. It is low after reset and throughout any frame gap.
- R3: Each cycle with `req_valid` and `grant_en` both high, while `stat_active` is high, adds one to `stat_count`. The count saturates at its maximum value. An access in the same cycle as the threshold hit is still counted.
- R4: `stat_count` is cleared on entry to a window. This includes a window that is directly followed by another window, and a single window that covers the whole frame and is re-entered at the frame wrap.
- R5: The threshold is the allowance minus the margin, or 0 when the margin is at least the allowance. When the count, including the access of the current cycle, reaches the threshold, `grant_en` is low from the next cycle until the window ends.
- R6: `irq` is a single-cycle pulse in the cycle after the threshold hit, and the same edge sets `stat_sticky`.
- R7: Writing the command register with data bit 1 set clears `stat_sticky`. A threshold hit in the same cycle wins over the clear.
- R8: `stat_cfg_err` is high, one cycle after the table changes, when the sum of the allowances of the valid windows exceeds the capacity.
- R9: During a frame gap nothing is counted, and `stat_count` keeps its value until the next window entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable; advances the frame slot |
| req_valid | input | 1 | Core shared-access request this cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW (5) | Configuration register address |
| cfg_wdata | input | W (16) | Configuration write data |
| grant_en | output | 1 | Shared access allowed this cycle |
| irq | output | 1 | Suspension interrupt pulse |
| stat_sticky | output | 1 | Sticky suspension flag |
| stat_count | output | W (16) | Accesses counted in the current or last window |
| stat_window | output | IW (2) | Index of the active window |
| stat_active | output | 1 | A window is active |
| stat_cfg_err | output | 1 | Allowances exceed capacity |

## Verification
Two situations are hard to reach from the ports. The first is a threshold hit in the last cycle of a window that runs straight into the next window, or into itself across the frame wrap. There the clear on entry must win over the suspension. The stimulus reaches it with a table whose windows touch end to end, then with a single window that spans the whole frame under continuous requests. The second is a margin larger than the allowance, which forces a hit on the first access after entry. It is set up by raising the margin while a window is already suspended, so the next entry starts from a zero threshold.

// File: rtl/bbe_pkg.sv
package bbe_pkg;
  // window field codes (address bits 1:0 when bit 4 is 0)
  localparam logic [1:0] FLD_START = 2'd0;
  localparam logic [1:0] FLD_END   = 2'd1;
  localparam logic [1:0] FLD_ALLOW = 2'd2;
  // global register codes (address bits 1:0 when bit 4 is 1)
  localparam logic [1:0] GLB_FRAME  = 2'd0;
  localparam logic [1:0] GLB_MARGIN = 2'd1;
  localparam logic [1:0] GLB_CAP    = 2'd2;
  localparam logic [1:0] GLB_CMD    = 2'd3;
  localparam int CMD_RUN_BIT = 0;
  localparam int CMD_CLR_BIT = 1;
endpackage

// File: rtl/bbe_cfg_regs.sv
module bbe_cfg_regs
  import bbe_pkg::*;
#(
  parameter int NWIN = 4,
  parameter int W    = 16,
  parameter int IW   = 2,
  parameter int AW   = IW + 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [AW-1:0]             cfg_addr,
  input  logic [W-1:0]              cfg_wdata,
  output logic [NWIN-1:0][W-1:0]    win_start,
  output logic [NWIN-1:0][W-1:0]    win_end,
  output logic [NWIN-1:0][W-1:0]    win_allow,
  output logic [W-1:0]              frame_len,
  output logic [W-1:0]              margin,
  output logic                      run_en,
  output logic                      clr_sticky,
  output logic                      cfg_err
);
  localparam int SW = W + IW + 1;

  logic          glb_sel;
  logic [1:0]    fld;
  logic [IW-1:0] wsel;
  logic [W-1:0]  capacity;
  logic [SW-1:0] allow_sum;

  assign glb_sel = cfg_addr[AW-1];
  assign fld     = cfg_addr[1:0];
  assign wsel    = cfg_addr[AW-2:2];

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        win_start[i] <= '0;
        win_end[i]   <= '0;
        win_allow[i] <= '0;
      end else if (cfg_we && !glb_sel && wsel == IW'(i)) begin
        case (fld)
          FLD_START: win_start[i] <= cfg_wdata;
          FLD_END:   win_end[i]   <= cfg_wdata;
          FLD_ALLOW: win_allow[i] <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_len <= '0;
      margin    <= '0;
      capacity  <= '0;
      run_en    <= 1'b0;
    end else if (cfg_we && glb_sel) begin
      case (fld)
        GLB_FRAME:  frame_len <= cfg_wdata;
        GLB_MARGIN: margin    <= cfg_wdata;
        GLB_CAP:    capacity  <= cfg_wdata;
        default:    run_en    <= cfg_wdata[CMD_RUN_BIT];
      endcase
    end
  end

  assign clr_sticky = cfg_we && glb_sel && fld == GLB_CMD && cfg_wdata[CMD_CLR_BIT];

  always_comb begin
    allow_sum = '0;
    for (int i = 0; i < NWIN; i++)
      if (win_start[i] < win_end[i]) allow_sum = allow_sum + SW'(win_allow[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= allow_sum > SW'(capacity);
  end
endmodule

// File: rtl/bbe_win_decode.sv
module bbe_win_decode #(
  parameter int NWIN = 4,
  parameter int W    = 16,
  parameter int IW   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   run_en,
  input  logic                   tick,
  input  logic [W-1:0]           frame_len,
  input  logic [NWIN-1:0][W-1:0] win_start,
  input  logic [NWIN-1:0][W-1:0] win_end,
  output logic                   act_now,
  output logic [IW-1:0]          idx_now,
  output logic                   enter_now,
  output logic                   act_q,
  output logic [IW-1:0]          idx_q
);
  logic [W-1:0]    slot;
  logic            wrap_q;
  logic            last_slot;
  logic [NWIN-1:0] in_win;

  assign last_slot = ({1'b0, slot} + (W+1)'(1)) >= {1'b0, frame_len};

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      slot   <= '0;
      wrap_q <= 1'b0;
    end else if (tick) begin
      slot   <= last_slot ? '0 : slot + 1'b1;
      wrap_q <= last_slot;
    end else begin
      wrap_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NWIN; i++) begin : g_cmp
    assign in_win[i] = run_en && (win_start[i] < win_end[i]) &&
                       (slot >= win_start[i]) && (slot < win_end[i]);
  end

  always_comb begin
    idx_now = '0;
    for (int i = NWIN - 1; i >= 0; i--)
      if (in_win[i]) idx_now = IW'(i);
  end

  assign act_now   = |in_win;
  assign enter_now = act_now && (!act_q || idx_now != idx_q || wrap_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else begin
      act_q <= act_now;
      idx_q <= idx_now;
    end
  end

  assert_timer_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (run_en && !tick) |=> $stable(slot));
  assert_idle_index_R1: assert property (@(posedge clk) disable iff (rst)
    !act_now |=> (idx_q == '0));
endmodule

// File: rtl/bbe_budget_ctr.sv
module bbe_budget_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  input  logic         act_q,
  input  logic         act_now,
  input  logic         enter_now,
  input  logic [W-1:0] thr,
  input  logic         clr_sticky,
  output logic         grant_q,
  output logic         irq_q,
  output logic         sticky_q,
  output logic [W-1:0] cnt_q
);
  logic         susp_q;
  logic         acc;
  logic         hit;
  logic         susp_nx;
  logic [W-1:0] cnt1;

  assign acc     = req_valid && grant_q;
  assign cnt1    = (act_q && acc && cnt_q != '1) ? cnt_q + 1'b1 : cnt_q;
  assign hit     = act_q && !susp_q && (cnt1 >= thr);
  assign susp_nx = susp_q || hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      susp_q   <= 1'b0;
      grant_q  <= 1'b0;
      irq_q    <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      irq_q    <= hit;
      sticky_q <= hit || (sticky_q && !clr_sticky);
      if (enter_now) begin
        cnt_q   <= '0;
        susp_q  <= 1'b0;
        grant_q <= 1'b1;
      end else begin
        cnt_q   <= cnt1;
        susp_q  <= susp_nx;
        grant_q <= act_now && !susp_nx;
      end
    end
  end

  assert_block_after_hit_R5: assert property (@(posedge clk) disable iff (rst)
    (hit && !enter_now) |=> !grant_q);
  assert_irq_sets_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> sticky_q);
  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    (act_q && !enter_now && req_valid && grant_q && cnt_q != '1) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_gap_no_count_R9: assert property (@(posedge clk) disable iff (rst)
    (!act_q && !enter_now) |=> $stable(cnt_q));
  assert_clear_on_entry_R4: assert property (@(posedge clk) disable iff (rst)
    enter_now |=> cnt_q == '0);
endmodule

// File: rtl/shared_budget_enforcer.sv
module shared_budget_enforcer
  import bbe_pkg::*;
#(
  parameter int NWIN = 4,
  parameter int W    = 16,
  localparam int IW  = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int AW  = IW + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          req_valid,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [W-1:0]  cfg_wdata,
  output logic          grant_en,
  output logic          irq,
  output logic          stat_sticky,
  output logic [W-1:0]  stat_count,
  output logic [IW-1:0] stat_window,
  output logic          stat_active,
  output logic          stat_cfg_err
);
  logic [NWIN-1:0][W-1:0] win_start, win_end, win_allow;
  logic [W-1:0]  frame_len, margin, allow_sel, thr;
  logic          run_en, clr_sticky;
  logic          act_now, enter_now, act_q;
  logic [IW-1:0] idx_now, idx_q;

  bbe_cfg_regs #(.NWIN(NWIN), .W(W), .IW(IW), .AW(AW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .win_start(win_start), .win_end(win_end), .win_allow(win_allow),
    .frame_len(frame_len), .margin(margin), .run_en(run_en),
    .clr_sticky(clr_sticky), .cfg_err(stat_cfg_err)
  );

  bbe_win_decode #(.NWIN(NWIN), .W(W), .IW(IW)) u_dec (
    .clk(clk), .rst(rst), .run_en(run_en), .tick(tick), .frame_len(frame_len),
    .win_start(win_start), .win_end(win_end), .act_now(act_now), .idx_now(idx_now),
    .enter_now(enter_now), .act_q(act_q), .idx_q(idx_q)
  );

  assign allow_sel = win_allow[idx_q];
  assign thr       = (allow_sel > margin) ? allow_sel - margin : '0;

  bbe_budget_ctr #(.W(W)) u_ctr (
    .clk(clk), .rst(rst), .req_valid(req_valid), .act_q(act_q), .act_now(act_now),
    .enter_now(enter_now), .thr(thr), .clr_sticky(clr_sticky),
    .grant_q(grant_en), .irq_q(irq), .sticky_q(stat_sticky), .cnt_q(stat_count)
  );

  assign stat_window = idx_q;
  assign stat_active = act_q;

  assert_no_grant_in_gap_R2: assert property (@(posedge clk) disable iff (rst)
    !stat_active |-> !grant_en);
endmodule

// File: tb/shared_budget_enforcer_tb_top.sv
module shared_budget_enforcer_tb_top;
  localparam int NWIN = 4;
  localparam int W    = 16;
  localparam int MAXC = 65535;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        req_valid = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        grant_en, irq, stat_sticky, stat_active, stat_cfg_err;
  logic [15:0] stat_count;
  logic [1:0]  stat_window;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit started = 0;

  always #10 clk = ~clk;

  shared_budget_enforcer #(.NWIN(NWIN), .W(W)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .req_valid(req_valid),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .grant_en(grant_en), .irq(irq), .stat_sticky(stat_sticky),
    .stat_count(stat_count), .stat_window(stat_window),
    .stat_active(stat_active), .stat_cfg_err(stat_cfg_err)
  );

  // ---------------- behavioural reference model ----------------
  int m_slot, m_fnum, m_seen_fnum, m_act, m_idx, m_cnt, m_susp, m_grant;
  int m_irq, m_sticky, m_err, m_run, m_flen, m_margin, m_cap;
  int t_start[NWIN], t_end[NWIN], t_allow[NWIN];

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_slot = 0; m_fnum = 0; m_seen_fnum = 0; m_act = 0; m_idx = 0; m_cnt = 0;
      m_susp = 0; m_grant = 0; m_irq = 0; m_sticky = 0; m_err = 0; m_run = 0;
      m_flen = 0; m_margin = 0; m_cap = 0;
      foreach (t_start[i]) begin t_start[i] = 0; t_end[i] = 0; t_allow[i] = 0; end
    end else begin
      int a, ix, ent, acc, c1, th, h, sum, clr;
      a = 0; ix = 0;
      for (int i = NWIN - 1; i >= 0; i--)
        if (m_run != 0 && t_start[i] < t_end[i] && t_start[i] <= m_slot && m_slot < t_end[i]) begin
          a = 1; ix = i;
        end
      ent = (a != 0) && (m_act == 0 || ix != m_idx || m_fnum != m_seen_fnum);
      acc = (req_valid && m_grant != 0) ? 1 : 0;
      c1 = m_cnt;
      if (m_act != 0 && c1 < MAXC) c1 = c1 + acc;
      th = (t_allow[m_idx] > m_margin) ? t_allow[m_idx] - m_margin : 0;
      h = (m_act != 0 && m_susp == 0 && c1 >= th) ? 1 : 0;
      clr = (cfg_we && cfg_addr == 5'b10011 && cfg_wdata[1]) ? 1 : 0;
      sum = 0;
      for (int i = 0; i < NWIN; i++) if (t_start[i] < t_end[i]) sum += t_allow[i];
      m_err = (sum > m_cap) ? 1 : 0;
      m_irq = h;
      if (h != 0) m_sticky = 1; else if (clr != 0) m_sticky = 0;
      if (ent) begin
        m_cnt = 0; m_susp = 0; m_grant = 1;
      end else begin
        m_cnt = c1;
        m_susp = (m_susp != 0 || h != 0) ? 1 : 0;
        m_grant = (a != 0 && m_susp == 0) ? 1 : 0;
      end
      m_seen_fnum = m_fnum;
      m_act = a;
      m_idx = (a != 0) ? ix : 0;
      if (m_run == 0) m_slot = 0;
      else if (tick) begin
        if (m_slot + 1 >= m_flen) begin m_slot = 0; m_fnum++; end
        else m_slot++;
      end
      if (cfg_we) begin
        if (cfg_addr[4] == 1'b0) begin
          case (cfg_addr[1:0])
            2'd0: t_start[cfg_addr[3:2]] = cfg_wdata;
            2'd1: t_end[cfg_addr[3:2]]   = cfg_wdata;
            2'd2: t_allow[cfg_addr[3:2]] = cfg_wdata;
            default: ;
          endcase
        end else begin
          case (cfg_addr[1:0])
            2'd0: m_flen = cfg_wdata;
            2'd1: m_margin = cfg_wdata;
            2'd2: m_cap = cfg_wdata;
            default: m_run = cfg_wdata[0];
          endcase
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R1 stat_active", stat_active, m_act);
      chk("R1 stat_window", stat_window, m_idx);
      chk("R2 grant_en", grant_en, m_grant);
      chk("R3 stat_count", stat_count, m_cnt);
      chk("R6 irq", irq, m_irq);
      chk("R7 stat_sticky", stat_sticky, m_sticky);
      chk("R8 stat_cfg_err", stat_cfg_err, m_err);
    end
  end

  function automatic logic [4:0] wa(input int i, input int f);
    return {1'b0, 2'(i), 2'(f)};
  endfunction
  function automatic logic [4:0] ga(input int f);
    return {1'b1, 2'b00, 2'(f)};
  endfunction

  task automatic cfg_write(input logic [4:0] a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_irq();
    do @(negedge clk); while (irq !== 1'b1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    chk("R2 reset grant", grant_en, 0);
    chk("R6 reset irq", irq, 0);
    chk("R3 reset count", stat_count, 0);
    rst = 1'b0;

    // table: w0 [2,12) 6, w1 [12,22) 3, w2 [25,38) 20, frame 40, margin 1
    cfg_write(ga(0), 40);
    cfg_write(wa(0, 0), 2);  cfg_write(wa(0, 1), 12); cfg_write(wa(0, 2), 6);
    cfg_write(wa(1, 0), 12); cfg_write(wa(1, 1), 22); cfg_write(wa(1, 2), 3);
    cfg_write(wa(2, 0), 25); cfg_write(wa(2, 1), 38); cfg_write(wa(2, 2), 20);
    cfg_write(ga(1), 1);
    cfg_write(ga(2), 40);
    req_valid = 1'b1; tick = 1'b1;
    cfg_write(ga(3), 1);

    wait_irq();
    chk("R5 w0 count at hit", stat_count, 5);
    chk("R5 w0 blocked", grant_en, 0);
    chk("R6 sticky set", stat_sticky, 1);
    chk("R1 window 0", stat_window, 0);
    @(negedge clk);
    chk("R6 single pulse", irq, 0);

    do @(negedge clk); while (!(stat_active && stat_window == 2'd1));
    chk("R4 cleared on contiguous entry", stat_count, 0);
    chk("R2 grant on entry", grant_en, 1);
    wait_irq();
    chk("R5 w1 count at hit", stat_count, 2);

    cfg_write(ga(3), 3);
    chk("R7 sticky cleared", stat_sticky, 0);

    do @(negedge clk); while (stat_active);
    held = stat_count;
    @(negedge clk);
    chk("R9 gap count holds", stat_count, held);
    chk("R9 gap grant low", grant_en, 0);

    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      req_valid = ($urandom % 2) != 0;
      tick = ($urandom % 4) != 0;
    end
    req_valid = 1'b1; tick = 1'b1;

    cfg_write(ga(2), 20);
    @(negedge clk);
    chk("R8 over capacity", stat_cfg_err, 1);
    cfg_write(ga(2), 40);
    @(negedge clk);
    chk("R8 within capacity", stat_cfg_err, 0);

    // single window spanning the whole frame
    cfg_write(ga(3), 0);
    cfg_write(ga(0), 10);
    cfg_write(wa(0, 0), 0); cfg_write(wa(0, 1), 10); cfg_write(wa(0, 2), 4);
    cfg_write(wa(1, 1), 0); cfg_write(wa(2, 1), 0);
    cfg_write(ga(1), 0);
    cfg_write(ga(3), 1);
    wait_irq();
    chk("R5 zero margin count", stat_count, 4);
    do @(negedge clk); while (grant_en !== 1'b1);
    chk("R4 cleared on frame wrap", stat_count, 0);
    wait_irq();
    chk("R5 second frame count", stat_count, 4);
    cfg_write(ga(1), 9);
    wait_irq();
    chk("R5 margin above allowance", stat_count, 1);

    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      req_valid = ($urandom % 3) != 0;
      tick = ($urandom % 2) != 0;
    end
    @(negedge clk);
    finish_run();
  end
endmodule